// File: doc/BRIEF.md
# Quasi-Bidirectional Port Bank with Per-Pin Pull-Up Selection

This block holds three general-purpose 8-bit ports of a microcontroller-style core. The ports are reached over a simple register bus: an address, a byte write strobe, a single-bit write strobe with a bit index and value, a read strobe and a registered read-data return. Each pin has an output latch and a weak pull-up select bit. The pad is modelled as three signals: an active drive-low, a pull-up enable, and the sampled pad level that comes back in. A bench or a pad ring can therefore model any external driver.

A pin works as an output when software writes its latch: a 0 pulls the pad low and a 1 lets it go. It works as an input when its latch holds 1. With the pull-up selected, the pad then rests high unless something outside drives it low. With the pull-up deselected, the pin is open drain and the pad floats. Reads come in two kinds, chosen by a side-band input from the instruction decoder. Read-modify-write instructions read the latch. All other instructions read the pad through a two-flop synchronizer.

Top module: `quasi_port_bank`

## Requirements
- R1: After reset every latch holds 0xFF, so no pad_drive_low bit is set, and every pull-up select register holds 0x00, so every pad_pullup_en bit is set.
- R2: A byte write to a port data address loads that port's latch at the clock edge that samples the write. Port k's data address is 0x80 + 0x10·k, giving 0x80, 0x90 and 0xA0. From the next cycle, latch bit b = 0 sets pad_drive_low[8k+b] and 1 clears it.
- R3: A byte write to a pull-up address loads that port's select register. Port k's pull-up address is 0xB2 + k. Bit value 0 sets pad_pullup_en for the pin and 1 clears it (open drain). The drive-low output depends only on the latch, whatever the pull-up setting.
- R4: A bit write (sfr_bit_wr with sfr_bit_idx and sfr_bit_val) to a port data address changes only the indexed latch bit. When sfr_wr and sfr_bit_wr are both high, the byte write takes priority.
- R5: A bit write to a pull-up address, and any write to an unmapped address, leaves all latches and pull-up registers unchanged, as seen on the pad outputs.
- R6: A read with read_kind = 1 (latch read) at a port data address returns the latch contents on sfr_rdata in the cycle after sfr_rd.
- R7: A read with read_kind = 0 (pin read) at a port data address returns the synchronized pad level. A pad change applied before clock edge e0 is missed by reads sampled at e0 and e1, and is seen by reads sampled at e2 and later.
- R8: A read of a pull-up address returns the select register whatever read_kind is. A read of an unmapped address returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sfr_addr | input | 8 | Register address |
| sfr_wr | input | 1 | Byte write strobe |
| sfr_wdata | input | 8 | Byte write data |
| sfr_bit_wr | input | 1 | Single-bit write strobe |
| sfr_bit_idx | input | 3 | Bit index for a bit write |
| sfr_bit_val | input | 1 | Value for a bit write |
| sfr_rd | input | 1 | Read strobe |
| read_kind | input | 1 | 1 = latch read, 0 = pin read |
| sfr_rdata | output | 8 | Registered read data |
| pad_in | input | 24 | Pad level of all pins, port k at bits 8k+7..8k |
| pad_drive_low | output | 24 | Active drive-low per pin |
| pad_pullup_en | output | 24 | Weak pull-up enable per pin |

## Verification
The bench builds the block with its default parameters: three ports of eight pins, 8-bit addresses, data registers spaced 0x10 apart from 0x80, and a two-stage synchronizer. These values make the whole address map reachable, including the gaps between mapped registers. They also give a short, fixed pin-read latency, so a single directed sequence can pin down the exact edge at which a pad change first shows up. The bench models external pull-downs and pull-ups on the pads, so pin reads show the combined effect of latch, pull-up select and outside drivers.

// File: rtl/qp_pkg.sv
package qp_pkg;
   typedef enum logic {
      RD_PIN   = 1'b0,
      RD_LATCH = 1'b1
   } rd_kind_e;
endpackage

// File: rtl/qp_sync.sv
module qp_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("qp_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stage_q[s] <= '1;
         else if (s == 0) stage_q[s] <= d;
         else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
   end

   assign q = stage_q[STAGES-1];
endmodule

// File: rtl/qp_port.sv
module qp_port #(
   parameter int              W           = 8,
   parameter int              ADDR_W      = 8,
   parameter logic [ADDR_W-1:0] DATA_ADDR = '0,
   parameter logic [ADDR_W-1:0] PU_ADDR   = '0,
   parameter int              SYNC_STAGES = 2,
   localparam int             IDX_W       = $clog2(W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   input  logic [W-1:0]      wdata,
   input  logic              bit_wr,
   input  logic [IDX_W-1:0]  bit_idx,
   input  logic              bit_val,
   input  logic [W-1:0]      pad_in,
   output logic              sel_data,
   output logic              sel_pu,
   output logic [W-1:0]      latch_q,
   output logic [W-1:0]      pu_q,
   output logic [W-1:0]      pin_q,
   output logic [W-1:0]      drive_low,
   output logic [W-1:0]      pullup_en
);
   if (W < 2) begin : g_bad_width
      $error("qp_port: W must be at least 2");
   end

   logic [W-1:0] bit_mask;

   assign sel_data = (addr == DATA_ADDR);
   assign sel_pu   = (addr == PU_ADDR);

   always_comb begin
      bit_mask = '0;
      if (int'(bit_idx) < W) bit_mask[bit_idx] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         latch_q <= '1;
      end else if (wr && sel_data) begin
         latch_q <= wdata;
      end else if (bit_wr && sel_data) begin
         latch_q <= bit_val ? (latch_q | bit_mask) : (latch_q & ~bit_mask);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pu_q <= '0;
      else if (wr && sel_pu) pu_q <= wdata;
   end

   assign drive_low = ~latch_q;
   assign pullup_en = ~pu_q;

   qp_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pad_in),
      .q     (pin_q)
   );

   // R2: byte write lands on the pad drive
   p_bytewr_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && sel_data) |=> (drive_low == ~$past(wdata)));

   // R3: pull-up register write lands on the pull-up enable
   p_puwr_enable_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && sel_pu) |=> (pullup_en == ~$past(wdata)));

   // R4: bit write keeps the other bits
   p_bitwr_others_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_wr && !wr && sel_data) |=>
         (((latch_q ^ $past(latch_q)) & ~$past(bit_mask)) == '0));

   // R4: bit write sets the indexed bit to the given value
   p_bitwr_value_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_wr && !wr && sel_data) |=>
         ((latch_q & $past(bit_mask)) == ($past(bit_val) ? $past(bit_mask) : '0)));

   // R5: pull-up register ignores bit writes
   p_pu_no_bitwr_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_wr && !wr && sel_pu) |=> $stable(pullup_en));
endmodule

// File: rtl/quasi_port_bank.sv
module quasi_port_bank #(
   parameter int NUM_PORTS   = 3,
   parameter int PORT_W      = 8,
   parameter int ADDR_W      = 8,
   parameter int DATA_BASE   = 'h80,
   parameter int DATA_STRIDE = 'h10,
   parameter int PU_BASE     = 'hB2,
   parameter int SYNC_STAGES = 2,
   localparam int IDX_W      = $clog2(PORT_W),
   localparam int PINS       = NUM_PORTS * PORT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] sfr_addr,
   input  logic              sfr_wr,
   input  logic [PORT_W-1:0] sfr_wdata,
   input  logic              sfr_bit_wr,
   input  logic [IDX_W-1:0]  sfr_bit_idx,
   input  logic              sfr_bit_val,
   input  logic              sfr_rd,
   input  logic              read_kind,
   output logic [PORT_W-1:0] sfr_rdata,
   input  logic [PINS-1:0]   pad_in,
   output logic [PINS-1:0]   pad_drive_low,
   output logic [PINS-1:0]   pad_pullup_en
);
   import qp_pkg::*;

   if (DATA_BASE + (NUM_PORTS-1)*DATA_STRIDE >= (1 << ADDR_W)) begin : g_bad_data_map
      $error("quasi_port_bank: data addresses exceed the address width");
   end
   if (PU_BASE + NUM_PORTS - 1 >= (1 << ADDR_W)) begin : g_bad_pu_map
      $error("quasi_port_bank: pull-up addresses exceed the address width");
   end
   if (NUM_PORTS < 1) begin : g_bad_ports
      $error("quasi_port_bank: NUM_PORTS must be at least 1");
   end

   logic [PORT_W-1:0] lat_a [NUM_PORTS];
   logic [PORT_W-1:0] pu_a  [NUM_PORTS];
   logic [PORT_W-1:0] pin_a [NUM_PORTS];
   logic [NUM_PORTS-1:0] sel_d, sel_p;

   for (genvar k = 0; k < NUM_PORTS; k++) begin : g_port
      localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(DATA_BASE + k*DATA_STRIDE);
      localparam logic [ADDR_W-1:0] A_PU   = ADDR_W'(PU_BASE + k);

      qp_port #(
         .W           (PORT_W),
         .ADDR_W      (ADDR_W),
         .DATA_ADDR   (A_DATA),
         .PU_ADDR     (A_PU),
         .SYNC_STAGES (SYNC_STAGES)
      ) u_port (
         .clk       (clk),
         .rst_n     (rst_n),
         .addr      (sfr_addr),
         .wr        (sfr_wr),
         .wdata     (sfr_wdata),
         .bit_wr    (sfr_bit_wr),
         .bit_idx   (sfr_bit_idx),
         .bit_val   (sfr_bit_val),
         .pad_in    (pad_in[k*PORT_W +: PORT_W]),
         .sel_data  (sel_d[k]),
         .sel_pu    (sel_p[k]),
         .latch_q   (lat_a[k]),
         .pu_q      (pu_a[k]),
         .pin_q     (pin_a[k]),
         .drive_low (pad_drive_low[k*PORT_W +: PORT_W]),
         .pullup_en (pad_pullup_en[k*PORT_W +: PORT_W])
      );

      // R6: latch read returns the value driving the pads
      p_latch_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (sfr_rd && read_kind == RD_LATCH && sfr_addr == A_DATA) |=>
            (sfr_rdata == ~$past(pad_drive_low[k*PORT_W +: PORT_W])));

      // R8: pull-up read ignores read_kind
      p_pu_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (sfr_rd && sfr_addr == A_PU) |=>
            (sfr_rdata == ~$past(pad_pullup_en[k*PORT_W +: PORT_W])));
   end

   logic [PORT_W-1:0] rd_val;
   logic              any_hit;

   always_comb begin
      rd_val  = '0;
      any_hit = 1'b0;
      for (int k = 0; k < NUM_PORTS; k++) begin
         if (sel_d[k]) begin
            any_hit = 1'b1;
            rd_val  = (read_kind == RD_LATCH) ? lat_a[k] : pin_a[k];
         end else if (sel_p[k]) begin
            any_hit = 1'b1;
            rd_val  = pu_a[k];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sfr_rdata <= '0;
      else if (sfr_rd) sfr_rdata <= rd_val;
   end

   // R8: unmapped read returns zero
   p_unmapped_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (sfr_rd && !any_hit) |=> (sfr_rdata == '0));

   // R5: no decode hit means no pad output change
   p_unmapped_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ((sfr_wr || sfr_bit_wr) && !any_hit) |=>
         ($stable(pad_drive_low) && $stable(pad_pullup_en)));
endmodule

// File: tb/quasi_port_bank_tb.sv
module quasi_port_bank_tb;
   localparam int NP = 3;
   localparam int PW = 8;
   localparam int NPINS = NP * PW;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [7:0]       sfr_addr = '0;
   logic             sfr_wr = 1'b0;
   logic [7:0]       sfr_wdata = '0;
   logic             sfr_bit_wr = 1'b0;
   logic [2:0]       sfr_bit_idx = '0;
   logic             sfr_bit_val = 1'b0;
   logic             sfr_rd = 1'b0;
   logic             read_kind = 1'b0;
   logic [7:0]       sfr_rdata;
   logic [NPINS-1:0] pad_in;
   logic [NPINS-1:0] pad_drive_low;
   logic [NPINS-1:0] pad_pullup_en;
   logic [NPINS-1:0] ext_low = '0;
   logic [NPINS-1:0] ext_high = '0;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   logic [7:0] m_lat [NP];
   logic [7:0] m_pu  [NP];

   always #2.5 clk = ~clk;

   // pad: low when driven by the pin or outside, high by pull-up or outside
   assign pad_in = ~(pad_drive_low | ext_low) & (pad_pullup_en | ext_high);

   quasi_port_bank u_dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .sfr_addr      (sfr_addr),
      .sfr_wr        (sfr_wr),
      .sfr_wdata     (sfr_wdata),
      .sfr_bit_wr    (sfr_bit_wr),
      .sfr_bit_idx   (sfr_bit_idx),
      .sfr_bit_val   (sfr_bit_val),
      .sfr_rd        (sfr_rd),
      .read_kind     (read_kind),
      .sfr_rdata     (sfr_rdata),
      .pad_in        (pad_in),
      .pad_drive_low (pad_drive_low),
      .pad_pullup_en (pad_pullup_en)
   );

   function automatic logic [7:0] data_addr(int k);
      return 8'(8'h80 + 8'h10 * k);
   endfunction

   function automatic logic [7:0] pu_addr(int k);
      return 8'(8'hB2 + k);
   endfunction

   function automatic logic [NPINS-1:0] exp_drive();
      logic [NPINS-1:0] v;
      for (int k = 0; k < NP; k++) v[k*PW +: PW] = ~m_lat[k];
      return v;
   endfunction

   function automatic logic [NPINS-1:0] exp_pull();
      logic [NPINS-1:0] v;
      for (int k = 0; k < NP; k++) v[k*PW +: PW] = ~m_pu[k];
      return v;
   endfunction

   function automatic logic [7:0] exp_pin(int k);
      logic [7:0] el, eh;
      el = ext_low[k*PW +: PW];
      eh = ext_high[k*PW +: PW];
      return ~(~m_lat[k] | el) & (~m_pu[k] | eh);
   endfunction

   function automatic logic [7:0] exp_read(logic [7:0] a, logic kind);
      for (int k = 0; k < NP; k++) begin
         if (a == data_addr(k)) return kind ? m_lat[k] : exp_pin(k);
         if (a == pu_addr(k)) return m_pu[k];
      end
      return 8'h00;
   endfunction

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic check_pads(string tag);
      check({tag, " drive"}, 32'(pad_drive_low), 32'(exp_drive()));
      check({tag, " pull"}, 32'(pad_pullup_en), 32'(exp_pull()));
   endtask

   task automatic byte_wr(logic [7:0] a, logic [7:0] d);
      sfr_addr = a; sfr_wdata = d; sfr_wr = 1'b1;
      @(negedge clk);
      sfr_wr = 1'b0;
      for (int k = 0; k < NP; k++) begin
         if (a == data_addr(k)) m_lat[k] = d;
         if (a == pu_addr(k)) m_pu[k] = d;
      end
   endtask

   task automatic bit_wr(logic [7:0] a, logic [2:0] i, logic v);
      sfr_addr = a; sfr_bit_idx = i; sfr_bit_val = v; sfr_bit_wr = 1'b1;
      @(negedge clk);
      sfr_bit_wr = 1'b0;
      for (int k = 0; k < NP; k++)
         if (a == data_addr(k)) m_lat[k][i] = v;
   endtask

   task automatic do_read(logic [7:0] a, logic kind, output logic [7:0] d);
      sfr_addr = a; read_kind = kind; sfr_rd = 1'b1;
      @(negedge clk);
      sfr_rd = 1'b0;
      d = sfr_rdata;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic [7:0] pick_addr();
      int r;
      logic [7:0] unm [4];
      unm[0] = 8'h81; unm[1] = 8'hB5; unm[2] = 8'h00; unm[3] = 8'hB1;
      r = $urandom % 3;
      if (r == 0) return data_addr($urandom % NP);
      if (r == 1) return pu_addr($urandom % NP);
      return unm[$urandom % 4];
   endfunction

   initial begin
      #200000;
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: run did not complete");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] rd;
      logic [7:0] a;
      void'($urandom(32'h0051_7A9E));
      for (int k = 0; k < NP; k++) begin m_lat[k] = 8'hFF; m_pu[k] = 8'h00; end

      // R1: reset state
      idle(1);
      check_pads("R1 in reset");
      rst_n = 1'b1;
      idle(3);
      check_pads("R1 after reset");
      for (int k = 0; k < NP; k++) begin
         do_read(data_addr(k), 1'b1, rd);
         check("R1 latch 0xFF", 32'(rd), 32'hFF);
         do_read(pu_addr(k), 1'b0, rd);
         check("R1 pull-up 0x00", 32'(rd), 32'h00);
      end

      // R2: byte write drives pads; R6 latch read back
      byte_wr(8'h90, 8'hA5);
      check_pads("R2 byte write port1");
      do_read(8'h90, 1'b1, rd);
      check("R6 latch read port1", 32'(rd), 32'hA5);

      // R3: open drain with latch 0 still drives low
      byte_wr(8'hB3, 8'hFF);
      check_pads("R3 open drain drive low");
      idle(3);
      // R7: floating open-drain pins read per external driver (none high)
      do_read(8'h90, 1'b0, rd);
      check("R7 open-drain pin read", 32'(rd), 32'(exp_pin(1)));
      // R8: pull-up read ignores read_kind
      do_read(8'hB3, 1'b1, rd);
      check("R8 pu read latch kind", 32'(rd), 32'hFF);

      // R4: bit writes
      bit_wr(8'h90, 3'd7, 1'b0);
      check_pads("R4 bit clear");
      bit_wr(8'h90, 3'd1, 1'b1);
      check_pads("R4 bit set");
      // R5: ignored writes
      bit_wr(8'hB3, 3'd2, 1'b0);
      check_pads("R5 bit write to pull-up");
      byte_wr(8'h91, 8'h00);
      check_pads("R5 unmapped byte write");
      do_read(8'hB5, 1'b1, rd);
      check("R8 unmapped read", 32'(rd), 32'h00);

      // R7: synchronizer latency, port 0 pin 3 pulled low outside
      byte_wr(8'h80, 8'hFF);
      byte_wr(8'hB2, 8'h00);
      idle(3);
      sfr_addr = 8'h80; read_kind = 1'b0; sfr_rd = 1'b1;
      ext_low[3] = 1'b1;
      @(negedge clk);
      check("R7 read at e0 old", 32'(sfr_rdata), 32'hFF);
      @(negedge clk);
      check("R7 read at e1 old", 32'(sfr_rdata), 32'hFF);
      @(negedge clk);
      sfr_rd = 1'b0;
      check("R7 read at e2 new", 32'(sfr_rdata), 32'hF7);
      do_read(8'h80, 1'b1, rd);
      check("R6 latch read ignores pad", 32'(rd), 32'hFF);
      ext_low[3] = 1'b0;
      idle(3);

      // random mix
      for (int it = 0; it < 400; it++) begin
         int op;
         op = $urandom % 6;
         a = pick_addr();
         case (op)
            0: byte_wr(data_addr($urandom % NP), 8'($urandom));
            1: bit_wr(a, 3'($urandom), 1'($urandom));
            2: byte_wr(a, 8'($urandom));
            3: begin
               ext_low  = NPINS'($urandom) & NPINS'($urandom);
               ext_high = NPINS'($urandom) & NPINS'($urandom);
            end
            default: begin
               logic kind;
               kind = 1'($urandom);
               do_read(a, kind, rd);
               check(kind ? "R6 R8 random latch read" : "R7 R8 random pin read",
                     32'(rd), 32'(exp_read(a, kind)));
            end
         endcase
         check_pads("R2 R3 R4 R5 random pads");
         idle(3);
      end

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule